// File: doc/BRIEF.md
# Chained Write-Back DMA for Engine Output

This block takes the 32-bit word stream that processing engines produce and stores it in memory. At launch it writes to one of two kinds of destination. The first is a single region whose address, length and discard option come straight from configuration inputs. The second is a linked chain of four-word descriptors held in memory, which the block reads one at a time. Each descriptor names a destination address, a length in words, a link to the next descriptor with a last-block flag, and a control flag that can discard the block's data or raise a block-end event. The fourth word is a tag, which is read and then ignored.

The incoming stream is cut exactly at block length boundaries, so words that do not fit in the current block go to the next one. A block marked for discard still takes in its words and advances its counters, but it performs no memory write. Data that arrives while the engine is idle is taken in and dropped, and an overflow pulse reports it. An idle engine is either one that was never launched or one whose last block has finished. Busy and waiting-for-data flags follow the life of a launch. A stop request makes the block now being written the final one.

Top module: `pdma_push`

## Requirements
- R1: A pulse on `start_cmd` with bit 1 set launches the engine, and that holds whether or not bit 0 is also set. A pulse with only bit 0 set leaves the engine idle.
- R2: With `chain_mode` low, a launch writes one block of `dir_len` words starting at `head_addr`, discarding them when `dir_discard` is high. That block raises no block-end event and ends with one stopped event.
- R3: `busy` and `waiting` are both high in the cycle after a launch. Both are low in the cycle after the stopped event.
- R4: While a descriptor is being read (`desc_rd_req` high), `in_ready` is low and no stream word is taken in.
- R5: Word k of a block (counting from 0) is written to the block address plus 4*k. When a block's length is used up, the next word goes to the next block.
- R6: In a discard block, words are taken in and counted against the length, but `mem_wr_en` stays low.
- R7: When a block ends and its control word has bit 31 set, `evt_block_end` pulses for exactly one cycle.
- R8: When a block ends and its link word has bit 0 set, `evt_stopped` pulses and the engine goes idle. Otherwise the next descriptor is read from the link word with bits 1:0 cleared.
- R9: While the engine is idle, `in_ready` is high. Every word offered is taken in without a memory write and pulses `evt_overflow`. This covers both before the first launch and after a chain has ended.
- R10: A descriptor is four words read at offsets 0, 4, 8 and 12: the destination address, the link word, the control word and the ignored tag. In the control word, bits LEN_W-1:0 are the length, bit 30 is discard and bit 31 is block-end enable; bits 28 and 29 have no effect.
- R11: A `stop_req` pulse while a block is being written makes that block the last one. The block's link is not followed.
- R12: A block of length zero ends without taking in any stream word.
- R13: `desc_ptr` takes the address of each descriptor as it is loaded.
- R14: While `mem_wr_ready` is low in a writing block, the offered word is held (`in_ready` low). No word is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_cmd | input | 2 | Launch pulse; bit 1 launches this engine, bit 0 belongs to the read side |
| chain_mode | input | 1 | 1: follow a descriptor chain, 0: single region |
| head_addr | input | 32 | Region address, or first descriptor address in chain mode |
| dir_len | input | LEN_W | Single-region length in words |
| dir_discard | input | 1 | Single-region discard option |
| stop_req | input | 1 | Pulse: make the current block the last |
| in_valid | input | 1 | Stream word valid |
| in_data | input | 32 | Stream word |
| in_ready | output | 1 | Stream word taken in this cycle when valid |
| mem_wr_en | output | 1 | Memory write request |
| mem_wr_addr | output | 32 | Memory write byte address |
| mem_wr_data | output | 32 | Memory write data |
| mem_wr_ready | input | 1 | Memory accepts the write |
| desc_rd_req | output | 1 | Descriptor word read request |
| desc_rd_addr | output | 32 | Descriptor word byte address |
| desc_rd_ack | input | 1 | Read data valid, one pulse per request |
| desc_rd_data | input | 32 | Descriptor read data |
| desc_ptr | output | 32 | Address of the descriptor last loaded |
| busy | output | 1 | A launch is in progress |
| waiting | output | 1 | The engine expects more engine data |
| evt_block_end | output | 1 | One-cycle block-end event |
| evt_stopped | output | 1 | One-cycle final-block-done event |
| evt_overflow | output | 1 | A word was dropped while idle |

## Verification
The bench feeds a chain whose middle block discards its data and whose outer blocks raise block-end events. A design that checks the length boundary one word late would write a word into the discarded block's slot, or it would shift the third block's address. A zero-length block is placed ahead of a one-word block; an engine that waits for data before closing an empty block would hang there or put the word in the wrong region. A stop request in the middle of a block must stop the chain without reading the linked descriptor, so a design that only latches the link flag at load would read further descriptors and raise extra events. Words sent before the first launch and after a chain ends must appear only as overflow pulses. Memory stalls must keep every word in order, so a design that drops the held word while writes are stalled shows gaps in the write log.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  localparam int DESC_WORDS   = 4;
  localparam int W_DST        = 0;
  localparam int W_LINK       = 1;
  localparam int W_CTRL       = 2;
  localparam int CTRL_DISCARD = 30;
  localparam int CTRL_IEN     = 31;
  localparam int LINK_LAST    = 0;
  localparam int LEN_MAX_W    = 28;

  typedef struct packed {
    logic [31:0]          dst;
    logic [31:0]          link;
    logic                 last;
    logic                 discard;
    logic                 ien;
    logic [LEN_MAX_W-1:0] len;
  } blk_cfg_t;

  function automatic logic [31:0] link_target(input logic [31:0] w);
    return {w[31:2], 2'b00};
  endfunction

  function automatic logic [31:0] word_after(input logic [31:0] a);
    return a + 32'd4;
  endfunction

  function automatic logic [31:0] word_offset(input logic [31:0] base, input int unsigned k);
    return base + 32'(k * 4);
  endfunction

endpackage

// File: rtl/pdma_desc_load.sv
module pdma_desc_load
  import pdma_pkg::*;
#(
  parameter int NWORDS = DESC_WORDS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [31:0] ptr,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  input  logic        rd_ack,
  input  logic [31:0] rd_data,
  output logic        done,
  output logic [31:0] base,
  output blk_cfg_t    cfg
);
  localparam int IDX_W = $clog2(NWORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

  logic             active;
  logic [IDX_W-1:0] idx;
  logic [31:0]      w_dst, w_link, w_ctrl;

  assign rd_req  = active;
  assign rd_addr = word_offset(base, 32'(idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      base   <= '0;
      done   <= 1'b0;
      w_dst  <= '0;
      w_link <= '0;
      w_ctrl <= '0;
    end else if (go) begin
      active <= 1'b1;
      idx    <= '0;
      base   <= ptr;
      done   <= 1'b0;
    end else if (active && rd_ack) begin
      if (idx == IDX_W'(W_DST))  w_dst  <= rd_data;
      if (idx == IDX_W'(W_LINK)) w_link <= rd_data;
      if (idx == IDX_W'(W_CTRL)) w_ctrl <= rd_data;
      if (idx == LAST_IDX) begin
        active <= 1'b0;
        done   <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  always_comb begin
    cfg.dst     = w_dst;
    cfg.link    = link_target(w_link);
    cfg.last    = w_link[LINK_LAST];
    cfg.discard = w_ctrl[CTRL_DISCARD];
    cfg.ien     = w_ctrl[CTRL_IEN];
    cfg.len     = w_ctrl[LEN_MAX_W-1:0];
  end

  // R10: the load completes only after the last word of the descriptor returned
  a_r10_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rd_ack) && $past(active));

  // R10: no read is outstanding once the load has finished
  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);

endmodule

// File: rtl/pdma_blk_track.sv
module pdma_blk_track
  import pdma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  blk_cfg_t         cfg,
  input  logic             step,
  input  logic             force_last,
  output logic [31:0]      cur_addr,
  output logic [31:0]      next_ptr,
  output logic [LEN_W-1:0] rem,
  output logic             discard,
  output logic             ien,
  output logic             last,
  output logic             rem_zero
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      next_ptr <= '0;
      rem      <= '0;
      discard  <= 1'b0;
      ien      <= 1'b0;
      last     <= 1'b0;
    end else if (load) begin
      cur_addr <= cfg.dst;
      next_ptr <= cfg.link;
      rem      <= cfg.len[LEN_W-1:0];
      discard  <= cfg.discard;
      ien      <= cfg.ien;
      last     <= cfg.last;
    end else begin
      if (step) begin
        cur_addr <= word_after(cur_addr);
        rem      <= rem - 1'b1;
      end
      if (force_last) last <= 1'b1;
    end
  end

  assign rem_zero = (rem == '0);

  // R5: each word taken in uses one unit of length and one word of address
  a_r5_len_step: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> rem == $past(rem) - 1'b1);
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> cur_addr == $past(cur_addr) + 32'd4);

  // R11: a stop request is never forgotten within a block
  a_r11_last_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    force_last && !load |=> last);

endmodule

// File: rtl/pdma_push.sv
module pdma_push
  import pdma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       start_cmd,
  input  logic             chain_mode,
  input  logic [31:0]      head_addr,
  input  logic [LEN_W-1:0] dir_len,
  input  logic             dir_discard,
  input  logic             stop_req,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  output logic             in_ready,
  output logic             mem_wr_en,
  output logic [31:0]      mem_wr_addr,
  output logic [31:0]      mem_wr_data,
  input  logic             mem_wr_ready,
  output logic             desc_rd_req,
  output logic [31:0]      desc_rd_addr,
  input  logic             desc_rd_ack,
  input  logic [31:0]      desc_rd_data,
  output logic [31:0]      desc_ptr,
  output logic             busy,
  output logic             waiting,
  output logic             evt_block_end,
  output logic             evt_stopped,
  output logic             evt_overflow
);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_XFER} st_t;

  st_t        st;
  logic       launch, launch_chain, launch_direct;
  logic       blk_end, blk_last, step, chain_q;
  logic       ld_go, ld_done;
  logic [31:0] ld_ptr, ld_base;
  blk_cfg_t   ld_cfg, dir_cfg, trk_cfg;
  logic       trk_load;
  logic [31:0] trk_addr, trk_next;
  logic [LEN_W-1:0] trk_rem;
  logic       trk_discard, trk_ien, trk_last, trk_zero;

  assign launch        = start_cmd[1];
  assign launch_chain  = launch && chain_mode;
  assign launch_direct = launch && !chain_mode;

  always_comb begin
    dir_cfg         = '0;
    dir_cfg.dst     = head_addr;
    dir_cfg.last    = 1'b1;
    dir_cfg.discard = dir_discard;
    dir_cfg.len     = LEN_MAX_W'(dir_len);
  end

  // block boundary: a loaded block with nothing left to take
  assign blk_end  = (st == ST_XFER) && trk_zero && !launch;
  assign blk_last = trk_last || stop_req;

  assign ld_go  = launch_chain || (blk_end && !blk_last);
  assign ld_ptr = launch_chain ? head_addr : trk_next;

  pdma_desc_load #(.NWORDS(DESC_WORDS)) u_load (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (ld_go),
    .ptr     (ld_ptr),
    .rd_req  (desc_rd_req),
    .rd_addr (desc_rd_addr),
    .rd_ack  (desc_rd_ack),
    .rd_data (desc_rd_data),
    .done    (ld_done),
    .base    (ld_base),
    .cfg     (ld_cfg)
  );

  assign trk_load = launch_direct || (st == ST_FETCH && ld_done && !launch);
  assign trk_cfg  = launch_direct ? dir_cfg : ld_cfg;

  pdma_blk_track #(.LEN_W(LEN_W)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (trk_load),
    .cfg        (trk_cfg),
    .step       (step),
    .force_last (stop_req && st == ST_XFER),
    .cur_addr   (trk_addr),
    .next_ptr   (trk_next),
    .rem        (trk_rem),
    .discard    (trk_discard),
    .ien        (trk_ien),
    .last       (trk_last),
    .rem_zero   (trk_zero)
  );

  // stream side
  always_comb begin
    case (st)
      ST_IDLE: in_ready = 1'b1;
      ST_XFER: in_ready = !trk_zero && (trk_discard || mem_wr_ready);
      default: in_ready = 1'b0;
    endcase
  end

  assign step        = (st == ST_XFER) && in_valid && in_ready;
  assign mem_wr_en   = (st == ST_XFER) && in_valid && !trk_zero && !trk_discard;
  assign mem_wr_addr = trk_addr;
  assign mem_wr_data = in_data;

  assign evt_overflow  = (st == ST_IDLE) && in_valid;
  assign evt_block_end = blk_end && trk_ien;
  assign evt_stopped   = blk_end && blk_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      busy     <= 1'b0;
      waiting  <= 1'b0;
      chain_q  <= 1'b0;
      desc_ptr <= '0;
    end else if (launch) begin
      st      <= chain_mode ? ST_FETCH : ST_XFER;
      busy    <= 1'b1;
      waiting <= 1'b1;
      chain_q <= chain_mode;
    end else begin
      case (st)
        ST_FETCH: if (ld_done) begin
          st       <= ST_XFER;
          desc_ptr <= ld_base;
        end
        ST_XFER: if (blk_end) begin
          if (blk_last) begin
            st      <= ST_IDLE;
            busy    <= 1'b0;
            waiting <= 1'b0;
          end else begin
            st <= ST_FETCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: both flags follow a launch and clear after the final block
  a_r3_flags_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy && waiting);
  a_r3_flags_off_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stopped |=> !busy && !waiting);

  // R4: no stream word is taken while a descriptor read is outstanding
  a_r4_no_take_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    desc_rd_req |-> !in_ready);

  // R9: dropped words never reach memory and only occur when idle
  a_r9_overflow_idle: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overflow |-> !busy && !mem_wr_en);

  // R2: the single-region block never raises a block-end event
  a_r2_direct_no_blkevt: assert property (@(posedge clk) disable iff (!rst_n)
    evt_block_end |-> chain_q);

  // R14: a stalled write keeps its address until memory accepts it
  a_r14_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en && !mem_wr_ready && !launch |=> mem_wr_addr == $past(mem_wr_addr));

  // R6: a discarding block issues no write
  a_r6_discard_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XFER) && trk_discard |-> !mem_wr_en);

  // R8: the stopped event and a descriptor read cannot begin together
  a_r8_stop_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stopped |=> !desc_rd_req);

  // R13: the visible pointer only moves on a completed descriptor load
  a_r13_ptr_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_done |=> $stable(desc_ptr));

  // R12: a drained block with nothing left never stalls the stream side
  a_r12_zero_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XFER) && trk_zero && !launch |=> st != ST_XFER || trk_load || $past(trk_load));

endmodule

// File: tb/pdma_push_test.sv
`timescale 1ns/1ps
module pdma_push_test;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]       start_cmd = '0;
  logic             chain_mode = 1'b0;
  logic [31:0]      head_addr = '0;
  logic [LEN_W-1:0] dir_len = '0;
  logic             dir_discard = 1'b0;
  logic             stop_req = 1'b0;
  logic             in_valid = 1'b0;
  logic [31:0]      in_data = '0;
  logic             in_ready, mem_wr_en, mem_wr_ready, desc_rd_req;
  logic [31:0]      mem_wr_addr, mem_wr_data, desc_rd_addr, desc_ptr;
  logic             desc_rd_ack;
  logic [31:0]      desc_rd_data;
  logic             busy, waiting, evt_block_end, evt_stopped, evt_overflow;

  pdma_push #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .chain_mode(chain_mode),
    .head_addr(head_addr), .dir_len(dir_len), .dir_discard(dir_discard),
    .stop_req(stop_req), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ready(mem_wr_ready), .desc_rd_req(desc_rd_req), .desc_rd_addr(desc_rd_addr),
    .desc_rd_ack(desc_rd_ack), .desc_rd_data(desc_rd_data), .desc_ptr(desc_ptr),
    .busy(busy), .waiting(waiting), .evt_block_end(evt_block_end),
    .evt_stopped(evt_stopped), .evt_overflow(evt_overflow)
  );

  // descriptor memory: one-cycle response, one ack per request
  logic [31:0] dmem [0:63];
  always_ff @(posedge clk) begin
    desc_rd_ack  <= desc_rd_req && !desc_rd_ack;
    desc_rd_data <= dmem[desc_rd_addr[7:2]];
  end

  // write sink with optional stall pattern
  logic       stall_en = 1'b0;
  logic [1:0] wcnt = '0;
  always_ff @(posedge clk) wcnt <= wcnt + 1'b1;
  assign mem_wr_ready = stall_en ? (wcnt != 2'd0) : 1'b1;

  // monitor
  int n_wr, n_ack, n_blk, n_stop, n_ovf;
  logic [31:0] wa [0:15];
  logic [31:0] wd [0:15];
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (mem_wr_en && mem_wr_ready) begin
        if (n_wr < 16) begin wa[n_wr] = mem_wr_addr; wd[n_wr] = mem_wr_data; end
        n_wr++;
      end
      if (desc_rd_ack) n_ack++;
      if (evt_block_end) n_blk++;
      if (evt_stopped) n_stop++;
      if (evt_overflow) n_ovf++;
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_wr = 0; n_ack = 0; n_blk = 0; n_stop = 0; n_ovf = 0;
  endtask

  task automatic launch(input logic [1:0] v);
    @(negedge clk); start_cmd = v;
    @(negedge clk); start_cmd = '0;
  endtask

  task automatic send(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = base + 32'(i);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic put_desc(input int a, input logic [31:0] dst, input logic [31:0] link,
                          input logic [31:0] ctrl);
    dmem[a/4]   = dst;
    dmem[a/4+1] = link;
    dmem[a/4+2] = ctrl;
    dmem[a/4+3] = 32'hDEAD_0000 | 32'(a);
  endtask

  task automatic t_reset();
    chk("R3 reset busy", 32'(busy), 0);
    chk("R3 reset waiting", 32'(waiting), 0);
    chk("R9 idle ready", 32'(in_ready), 1);
    chk("R13 reset ptr", desc_ptr, 0);
  endtask

  task automatic t_idle_drop();
    clear_logs();
    send(2, 32'h55);
    repeat (3) @(negedge clk);
    chk("R9 drop count before launch", 32'(n_ovf), 2);
    chk("R9 no write before launch", 32'(n_wr), 0);
  endtask

  task automatic t_fetch_bit_only();
    clear_logs();
    chain_mode = 1'b0; head_addr = 32'h500; dir_len = 16'd2;
    launch(2'b01);
    chk("R1 bit0 alone keeps idle", 32'(busy), 0);
  endtask

  task automatic t_direct(input logic [1:0] cmd, input logic disc, input logic stall);
    clear_logs();
    stall_en = stall;
    chain_mode = 1'b0; head_addr = 32'h700; dir_len = 16'd4; dir_discard = disc;
    launch(cmd);
    chk("R1/R3 busy after launch", 32'(busy), 1);
    chk("R3 waiting after launch", 32'(waiting), 1);
    send(4, 32'hC0);
    wait_idle();
    stall_en = 1'b0;
    chk("R2 stopped once", 32'(n_stop), 1);
    chk("R2 no block-end in region mode", 32'(n_blk), 0);
    chk("R3 busy clear", 32'(busy), 0);
    chk("R3 waiting clear", 32'(waiting), 0);
    if (disc) begin
      chk("R6 region discard writes", 32'(n_wr), 0);
    end else begin
      chk("R2 region write count", 32'(n_wr), 4);
      for (int k = 0; k < 4; k++) begin
        chk(stall ? "R14 addr under stall" : "R2 region addr", wa[k], 32'h700 + 32'(4*k));
        chk(stall ? "R14 data under stall" : "R2 region data", wd[k], 32'hC0 + 32'(k));
      end
    end
    dir_discard = 1'b0;
  endtask

  task automatic t_chain();
    clear_logs();
    put_desc(32'h40, 32'h1000, 32'h60,         32'h8000_0002);
    put_desc(32'h60, 32'h2000, 32'h82,         32'h7000_0001); // bits 28/29 set, discard
    put_desc(32'h80, 32'h3000, 32'h0000_0001,  32'h8000_0002);
    chain_mode = 1'b1; head_addr = 32'h40;
    launch(2'b10);
    send(5, 32'hA0);
    wait_idle();
    chk("R5/R6 chain write count", 32'(n_wr), 4);
    chk("R5 blk0 w0 addr", wa[0], 32'h1000);
    chk("R5 blk0 w1 addr", wa[1], 32'h1004);
    chk("R5 blk0 w1 data", wd[1], 32'hA1);
    chk("R6 discard skipped, blk2 addr", wa[2], 32'h3000);
    chk("R6 discard skipped, blk2 data", wd[2], 32'hA3);
    chk("R5 blk2 w1 addr", wa[3], 32'h3004);
    chk("R7 block-end count", 32'(n_blk), 2);
    chk("R8 stopped count", 32'(n_stop), 1);
    chk("R10 descriptor words read", 32'(n_ack), 12);
    chk("R13 last descriptor pointer", desc_ptr, 32'h80);
    clear_logs();
    send(2, 32'hEE);
    repeat (3) @(negedge clk);
    chk("R9 overflow after chain", 32'(n_ovf), 2);
    chk("R9 no write after chain", 32'(n_wr), 0);
  endtask

  task automatic t_zero_len();
    clear_logs();
    put_desc(32'hA0, 32'h9000, 32'hC0,        32'h8000_0000);
    put_desc(32'hC0, 32'h4000, 32'h0000_0001, 32'h0000_0001);
    chain_mode = 1'b1; head_addr = 32'hA0;
    launch(2'b11);
    send(1, 32'hB7);
    wait_idle();
    chk("R12 zero block then one word", 32'(n_wr), 1);
    chk("R12 word lands in second block", wa[0], 32'h4000);
    chk("R7 only first block enabled", 32'(n_blk), 1);
    chk("R8 stopped after second", 32'(n_stop), 1);
    chk("R13 pointer on second", desc_ptr, 32'hC0);
  endtask

  task automatic t_stop_req();
    clear_logs();
    put_desc(32'h40, 32'h1000, 32'h60, 32'h8000_0002);
    chain_mode = 1'b1; head_addr = 32'h40;
    launch(2'b10);
    send(1, 32'hD0);
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    chk("R11 still busy mid-block", 32'(busy), 1);
    send(1, 32'hD1);
    wait_idle();
    chk("R11 stopped after forced last", 32'(n_stop), 1);
    chk("R11 link not followed", 32'(n_ack), 4);
    chk("R11 pointer stays", desc_ptr, 32'h40);
    chk("R11 both words written", 32'(n_wr), 2);
    chk("R4 no word lost over fetch", wd[0], 32'hD0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) dmem[i] = '0;
    clear_logs();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_drop();
    t_fetch_bit_only();
    t_direct(2'b10, 1'b0, 1'b0);
    t_direct(2'b11, 1'b1, 1'b0);
    t_direct(2'b10, 1'b0, 1'b1);
    t_chain();
    t_zero_len();
    t_stop_req();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule